// File: doc/BRIEF.md
# Vectored Interrupt Controller with Edge and Level Capture

This block gathers thirty-two interrupt request lines into one interrupt output for a processor. Every line passes through a synchronising flip-flop chain before capture into a status word. Each line is fixed at build time as either edge type or level type. An enable word selects which status bits count as pending. The controller also reports the index of the lowest-numbered pending line, so software can dispatch without scanning.

Software reaches the controller through a single-cycle register port with no wait states, addressed in bytes. It can acknowledge edge events, and it can set or clear enable bits without a read-modify-write. A two-bit master word gates two things on their own: one bit allows hardware capture of the lines, the other allows the output to assert.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The register index is the byte address shifted right by two. Indices 0 to 7 select registers. A larger index reads as zero, and a write to it changes nothing.
- R2: Index 1 reads as the status word ANDed with the enable word. Writes to index 1 or to index 6 have no effect.
- R3: Index 6 reads as the position of the lowest set bit of the pending word. When no bit is pending it reads 32'hFFFF_FFFF.
- R4: irqOut is high exactly when master bit 0 and master bit 1 are both set and the pending word is nonzero.
- R5: A write to index 3 clears the status bits that are set in the written data. If a rising edge on an edge-type line is captured in the same cycle, that bit ends up set.
- R6: A write to index 4 ORs the data into the enable word, and a write to index 5 clears the enable bits set in the data. A write to index 2 stores the enable word, index 0 stores the status word, and index 7 stores the master word. Indices 3, 4 and 5 read as zero.
- R7: While master bit 1 is clear, the input lines do not change the status word and irqOut stays low.
- R8: A level-type line (EDGE_MASK bit clear) has a status bit that follows the line in both directions. A change on the line shows in the status word after the third rising clock edge that samples it.
- R9: An edge-type line (EDGE_MASK bit set) has a status bit that is set by a rising edge of the synchronised line. A falling line leaves the bit set. A line still held high after acknowledge does not set the bit again.
- R10: Read data is registered. A read updates busRdata at its clock edge with the register contents from before that edge, and busRdata holds between reads.
- R11: After reset every register is zero, irqOut is low and index 6 reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| srcIn | input | 32 | Interrupt request lines |
| irqOut | output | 1 | Interrupt to the processor |

## Verification
Two updates can land on the same status bit in the same cycle: a software acknowledge, and hardware capture of a new rising edge on an edge-type line. The bench forces this case. It raises an edge line, counts the two synchronising cycles, and issues the acknowledge at the edge where the rise is captured. It then reads the status word and expects that bit still set. Random traffic also mixes acknowledges and enable writes with line toggles, and a cycle-level model checks every cycle.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
  localparam int WORD_W    = 32;
  localparam int REG_COUNT = 8;
  localparam int IDX_W     = $clog2(REG_COUNT);

  typedef struct packed {
    logic             wrStatus;
    logic             wrEnable;
    logic             ackStatus;
    logic             setEnable;
    logic             clrEnable;
    logic             wrMaster;
    logic             rdEn;
    logic             rdHit;
    logic [IDX_W-1:0] rdIdx;
  } ctl_strobe_t;
endpackage

// File: rtl/irq_vector_decode.sv
module irq_vector_decode
  import irq_vector_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctl_strobe_t       ctl
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] wordIdx;
  logic              inRange;
  logic              doWrite;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign inRange = (32'(wordIdx) < REG_COUNT);
  assign doWrite = busValid && busWrite && inRange;

  always_comb begin
    ctl           = '0;
    ctl.rdIdx     = wordIdx[IDX_W-1:0];
    ctl.rdEn      = busValid && !busWrite;
    ctl.rdHit     = inRange;
    ctl.wrStatus  = doWrite && (wordIdx[IDX_W-1:0] == 3'd0);
    ctl.wrEnable  = doWrite && (wordIdx[IDX_W-1:0] == 3'd2);
    ctl.ackStatus = doWrite && (wordIdx[IDX_W-1:0] == 3'd3);
    ctl.setEnable = doWrite && (wordIdx[IDX_W-1:0] == 3'd4);
    ctl.clrEnable = doWrite && (wordIdx[IDX_W-1:0] == 3'd5);
    ctl.wrMaster  = doWrite && (wordIdx[IDX_W-1:0] == 3'd7);
  end

  // R1: at most one register update strobe per cycle
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.wrStatus, ctl.wrEnable, ctl.ackStatus,
              ctl.setEnable, ctl.clrEnable, ctl.wrMaster}));

  // R1: an out-of-range access raises no write strobe
  a_r1_oob_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && !ctl.rdHit) |->
      !(ctl.wrStatus || ctl.wrEnable || ctl.ackStatus ||
        ctl.setEnable || ctl.clrEnable || ctl.wrMaster));
endmodule

// File: rtl/irq_vector_datapath.sv
module irq_vector_datapath
  import irq_vector_pkg::*;
#(
  parameter logic [WORD_W-1:0] EDGE_MASK   = '0,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_strobe_t       ctl,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] srcIn,
  output logic [WORD_W-1:0] rdata,
  output logic              irqOut
);
  logic [SYNC_STAGES-1:0][WORD_W-1:0] syncQ;
  logic [WORD_W-1:0] srcSync, prevQ, risePulse;
  logic [WORD_W-1:0] statusQ, statusBase, statusNext;
  logic [WORD_W-1:0] enableQ, enableNext;
  logic [WORD_W-1:0] masterQ;
  logic [WORD_W-1:0] pending, vector;
  logic              hwEn, outEn;

  // synchroniser chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncQ[0] <= '0;
    else        syncQ[0] <= srcIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) syncQ[s] <= '0;
      else        syncQ[s] <= syncQ[s-1];
    end
  end

  assign srcSync   = syncQ[SYNC_STAGES-1];
  assign risePulse = srcSync & ~prevQ;
  assign hwEn      = masterQ[1];
  assign outEn     = masterQ[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevQ <= '0;
    else        prevQ <= srcSync;
  end

  // software view of the status word before capture
  always_comb begin
    if (ctl.wrStatus)       statusBase = wdata;
    else if (ctl.ackStatus) statusBase = statusQ & ~wdata;
    else                    statusBase = statusQ;
  end

  // per-line capture variant chosen by EDGE_MASK
  for (genvar i = 0; i < WORD_W; i++) begin : g_cap
    if (EDGE_MASK[i]) begin : g_edge
      assign statusNext[i] = statusBase[i] | (hwEn & risePulse[i]);
    end else begin : g_level
      assign statusNext[i] = hwEn ? srcSync[i] : statusBase[i];
    end
  end

  always_comb begin
    enableNext = enableQ;
    if (ctl.wrEnable)       enableNext = wdata;
    else if (ctl.setEnable) enableNext = enableQ | wdata;
    else if (ctl.clrEnable) enableNext = enableQ & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusQ <= '0;
      enableQ <= '0;
      masterQ <= '0;
    end else begin
      statusQ <= statusNext;
      enableQ <= enableNext;
      if (ctl.wrMaster) masterQ <= wdata;
    end
  end

  assign pending = statusQ & enableQ;

  // lowest-index priority encoder
  always_comb begin
    vector = '1;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (pending[i]) vector = WORD_W'(i);
    end
  end

  assign irqOut = outEn && hwEn && (pending != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (ctl.rdEn) begin
      if (!ctl.rdHit) begin
        rdata <= '0;
      end else begin
        case (ctl.rdIdx)
          3'd0:    rdata <= statusQ;
          3'd1:    rdata <= pending;
          3'd2:    rdata <= enableQ;
          3'd6:    rdata <= vector;
          3'd7:    rdata <= masterQ;
          default: rdata <= '0;
        endcase
      end
    end
  end

  // R3: vector names a pending bit with nothing pending below it
  a_r3_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (pending != '0) |->
      (pending[vector[4:0]] && ((pending & ((WORD_W'(1) << vector[4:0]) - 1)) == '0)));

  // R3: empty pending word yields all ones
  a_r3_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> (vector == '1));

  // R7: with capture off and no status write, status holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hwEn && !ctl.wrStatus && !ctl.ackStatus) |=> $stable(statusQ));

  // R9: edge-type bits only drop through software
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.wrStatus && !ctl.ackStatus) |=>
      (($past(statusQ) & EDGE_MASK & ~statusQ) == '0));

  // R6: set-enable leaves every written bit set
  a_r6_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.setEnable |=> ((enableQ & $past(wdata)) == $past(wdata)));

  // R5: acknowledge with capture off clears the named bits
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.ackStatus && !hwEn) |=> ((statusQ & $past(wdata)) == '0));

  // R4: output never asserts while capture is disabled
  a_r4_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !hwEn |-> !irqOut);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vector_pkg::*;
#(
  parameter int                ADDR_W      = 6,
  parameter logic [WORD_W-1:0] EDGE_MASK   = 32'hFFFF_0000,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [31:0]       srcIn,
  output logic              irqOut
);
  ctl_strobe_t ctl;

  irq_vector_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .ctl      (ctl)
  );

  irq_vector_datapath #(
    .EDGE_MASK   (EDGE_MASK),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .wdata  (busWdata),
    .srcIn  (srcIn),
    .rdata  (busRdata),
    .irqOut (irqOut)
  );
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  localparam logic [31:0] EDGE = 32'hFFFF_0000;
  localparam int ADDR_W = 6;

  logic clk = 0;
  logic rst_n = 0;
  logic busValid = 0, busWrite = 0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWdata = '0, srcDrv = '0;
  logic [31:0] busRdata;
  logic irqOut;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [31:0] mS0 = 0, mS1 = 0, mPrev = 0, mStat = 0, mEn = 0, mMer = 0, mRd = 0;
  int lastIdx = 0;

  always #4 clk = ~clk;

  irq_vector_ctrl #(.ADDR_W(ADDR_W), .EDGE_MASK(EDGE)) u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .srcIn(srcDrv), .irqOut(irqOut)
  );

  function automatic logic [31:0] lowVec(input logic [31:0] p);
    logic [31:0] v = '1;
    for (int i = 31; i >= 0; i--) if (p[i]) v = i;
    return v;
  endfunction

  function automatic logic [31:0] regVal(input int idx);
    case (idx)
      0: return mStat;
      1: return mStat & mEn;
      2: return mEn;
      6: return lowVec(mStat & mEn);
      7: return mMer;
      default: return 0;
    endcase
  endfunction

  function automatic string tagFor(input int idx);
    case (idx)
      0: return "R8";
      1: return "R2";
      6: return "R3";
      2, 3, 4, 5, 7: return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one bus cycle, model advanced at the edge, outputs compared after it
  task automatic step(input bit v, input bit w, input int idx, input logic [31:0] d);
    logic [31:0] base, sNew;
    busValid = v; busWrite = w; busAddr = ADDR_W'(idx << 2); busWdata = d;
    @(posedge clk);
    if (v && !w) begin
      mRd = (idx < 8) ? regVal(idx) : 0;
      lastIdx = idx;
    end
    base = mStat;
    if (v && w && idx == 0) base = d;
    else if (v && w && idx == 3) base = mStat & ~d;
    sNew = mMer[1] ? (((base | (mS1 & ~mPrev)) & EDGE) | (mS1 & ~EDGE)) : base;
    if (v && w && idx == 2) mEn = d;
    else if (v && w && idx == 4) mEn = mEn | d;
    else if (v && w && idx == 5) mEn = mEn & ~d;
    if (v && w && idx == 7) mMer = d;
    mStat = sNew;
    mPrev = mS1; mS1 = mS0; mS0 = srcDrv;
    @(negedge clk);
    chk(tagFor(lastIdx), busRdata, mRd);
    chk("R4", {31'b0, irqOut}, {31'b0, mMer[0] & mMer[1] & ((mStat & mEn) != 0)});
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0);
  endtask

  task automatic rd(input int idx, output logic [31:0] val);
    step(1, 0, idx, 0);
    val = busRdata;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    chk("R11", {31'b0, irqOut}, 0);
    rd(6, r); chk("R11", r, 32'hFFFF_FFFF);
    rd(0, r); chk("R11", r, 0);

    // level line 5 and edge line 20
    step(1, 1, 7, 3);
    step(1, 1, 4, (1 << 5) | (1 << 20) | (1 << 17));
    srcDrv[5] = 1;
    idle(3);
    rd(0, r); chk("R8", r, 32'h20);
    chk("R4", {31'b0, irqOut}, 1);
    rd(6, r); chk("R3", r, 5);
    srcDrv[5] = 0;
    idle(3);
    rd(0, r); chk("R8", r, 0);

    // edge line: latched, survives drop, not re-set after ack
    srcDrv[20] = 1;
    idle(3);
    srcDrv[20] = 0;
    idle(3);
    rd(0, r); chk("R9", r, 1 << 20);
    srcDrv[20] = 1;
    idle(4);
    step(1, 1, 3, 1 << 20);
    idle(4);
    rd(0, r); chk("R9", r, 0);
    srcDrv[20] = 0;

    // same-cycle acknowledge and capture on line 17
    srcDrv[17] = 1; idle(4);
    srcDrv[17] = 0; idle(3);
    rd(0, r); chk("R5", r, 1 << 17);
    srcDrv[17] = 1;
    idle(2);
    step(1, 1, 3, 1 << 17);
    rd(0, r); chk("R5", r, 1 << 17);
    step(1, 1, 3, 1 << 17);
    rd(0, r); chk("R5", r, 0);
    srcDrv[17] = 0;

    // pending and vector not writable, out-of-range ignored
    step(1, 1, 1, 32'hFFFF_FFFF);
    step(1, 1, 6, 32'h0);
    rd(1, r); chk("R2", r, 0);
    step(1, 1, 10, 32'hFFFF_FFFF);
    rd(10, r); chk("R1", r, 0);
    rd(2, r); chk("R1", r, (1 << 5) | (1 << 20) | (1 << 17));
    step(1, 1, 5, 1 << 20);
    rd(2, r); chk("R6", r, (1 << 5) | (1 << 17));
    rd(4, r); chk("R6", r, 0);

    // capture disabled
    step(1, 1, 7, 1);
    srcDrv[5] = 1; idle(4);
    rd(0, r); chk("R7", r, 0);
    step(1, 1, 0, 1 << 5);
    chk("R7", {31'b0, irqOut}, 0);
    rd(10, r); chk("R10", r, 0);
    idle(2); chk("R10", busRdata, 0);
    srcDrv = 0;

    // random traffic
    for (int n = 0; n < 6000; n++) begin
      int idx;
      logic [31:0] d;
      bit v, w;
      if ($urandom % 4 == 0) srcDrv = srcDrv ^ (32'h1 << ($urandom % 32));
      v = ($urandom % 3) != 0;
      w = $urandom % 2;
      idx = $urandom % 12;
      d = $urandom;
      if (idx == 7) d = ($urandom % 5 == 0) ? d : 32'h3;
      if (idx == 0 || idx == 3) d = d & $urandom;
      step(v, w, idx, d);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule